// File: doc/BRIEF.md
# Packed SIMD lane ALU

This block performs lane-wise integer arithmetic on one XLEN-wide register value. The register is split into INT8 lanes or INT16 lanes. The lane type comes from the 5-bit destination register specifier. Bit 4 of that specifier selects the element width. Bit 3 selects signed ordering (the lower half of each bank) or unsigned ordering (the upper half). The same type applies to both operands and to the result.

Every lane that fits in the register is computed, including lanes at or above the maximum vector length (MVL). MVL is XLEN/16, so it is 2 on a 32-bit datapath and 4 on a 64-bit one. The one exception is lanes whose index is at or above the current vector length (VL) and below MVL: these are written as zero. A source specifier of 0 names the hardwired-zero register, so that operand reads as zero whatever is on its data port.

A two-state machine tracks result validity:
- `ST_IDLE` means no result is held.
- `ST_EMIT` means the result register holds a fresh result.

It has three transitions:
- *accept*: IDLE to EMIT, when `in_valid` is high.
- *stream*: EMIT to EMIT, when `in_valid` is high.
- *drain*: EMIT to IDLE, when `in_valid` is low.

Top module: `simd_lane_alu`

## Requirements
- R1: `dst_spec[4]` = 0 selects INT8 lanes (XLEN/8 lanes). `dst_spec[4]` = 1 selects INT16 lanes (XLEN/16 lanes). Lane i occupies bits [i*W +: W].
- R2: `dst_spec[3]` = 0 gives signed lane ordering. `dst_spec[3]` = 1 gives unsigned lane ordering.
- R3: op 0 (add) sums each lane modulo 2^W. No carry passes into the next lane.
- R4: op 1 (subtract) computes src1 lane minus src2 lane modulo 2^W. No borrow crosses a lane.
- R5: op 2 (less-than) sets a lane to all ones when the src1 lane is below the src2 lane under the R2 ordering. Otherwise the lane is all zeros.
- R6: op 3 (equal) sets a lane to all ones when the two lanes are equal. Otherwise the lane is all zeros.
- R7: A lane whose index i satisfies VL <= i < MVL is zero in the result, where MVL = XLEN/16.
- R8: Lanes with index >= MVL are computed normally whatever the value of VL.
- R9: A source specifier equal to 0 makes that operand zero, regardless of its data port.
- R10: The result and `out_valid` appear one cycle after `in_valid`. `out_valid` falls in the cycle after a cycle without `in_valid`. Reset clears `out_valid` and `out_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | 0 add, 1 subtract, 2 less-than, 3 equal |
| dst_spec | input | 5 | Destination specifier; bit 4 is width, bit 3 is unsigned |
| src1_spec | input | 5 | First source specifier; 0 reads zero |
| src2_spec | input | 5 | Second source specifier; 0 reads zero |
| src1_data | input | XLEN | First source register value |
| src2_data | input | XLEN | Second source register value |
| vl | input | VLW | Current vector length |
| out_valid | output | 1 | Result valid strobe |
| out_data | output | XLEN | Registered packed result |

## Verification
Every result is due exactly one clock edge after the request that produced it. This is because the lane logic is combinational and feeds a single result register and the state register. The bench therefore drives a request just after a falling edge. It computes the expected lane values for that request with its own integer model. At the next falling edge it compares `out_valid` and `out_data` against that expectation. The compare runs on every clock, including idle cycles, where only `out_valid` is due low.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_LT  = 2'd2,
        OP_EQ  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic wide;
        logic is_unsigned;
    } elem_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

endpackage

// File: rtl/simd_spec_decode.sv
module simd_spec_decode
    import simd_alu_pkg::*;
(
    input  logic [4:0] spec,
    output elem_kind_t kind
);
    logic spec_idx_unused;

    // bit 4 picks the bank (element width), bit 3 the half of the bank
    assign kind.wide        = spec[4];
    assign kind.is_unsigned = spec[3];
    assign spec_idx_unused  = ^spec[2:0];
endmodule

// File: rtl/simd_lane_op.sv
module simd_lane_op
    import simd_alu_pkg::*;
#(
    parameter int EW = 8
) (
    input  alu_op_e       op,
    input  logic          is_unsigned,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] r
);
    logic [EW-1:0] sum;
    logic [EW-1:0] diff;
    logic          a_ext;
    logic          b_ext;
    logic          less;

    assign sum   = a + b;
    assign diff  = a - b;
    assign a_ext = ~is_unsigned & a[EW-1];
    assign b_ext = ~is_unsigned & b[EW-1];
    assign less  = $signed({a_ext, a}) < $signed({b_ext, b});

    always_comb begin
        unique case (op)
            OP_ADD:  r = sum;
            OP_SUB:  r = diff;
            OP_LT:   r = {EW{less}};
            OP_EQ:   r = {EW{a == b}};
            default: r = '0;
        endcase
    end

    // R5/R6: compare results are full lane masks
    always_comb begin
        if (op == OP_LT || op == OP_EQ) begin
            p_cmp_mask_r5: assert (r == '0 || r == '1)
                else $error("compare lane not a full mask");
        end
    end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int EW   = 8,
    parameter int MVL  = XLEN / 16,
    parameter int VLW  = $clog2(MVL + 1)
) (
    input  alu_op_e         op,
    input  logic            is_unsigned,
    input  logic [VLW-1:0]  vl,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] r
);
    localparam int NLANE = XLEN / EW;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [EW-1:0] raw;
        logic          keep;

        simd_lane_op #(.EW(EW)) i_op (
            .op          (op),
            .is_unsigned (is_unsigned),
            .a           (a[i*EW +: EW]),
            .b           (b[i*EW +: EW]),
            .r           (raw)
        );

        if (i < MVL) begin : g_tail_zero
            assign keep = (32'(vl) > i);
        end else begin : g_beyond_mvl
            assign keep = 1'b1;
        end

        assign r[i*EW +: EW] = keep ? raw : '0;
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int MVL  = XLEN / 16,
    parameter int VLW  = $clog2(MVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [4:0]      dst_spec,
    input  logic [4:0]      src1_spec,
    input  logic [4:0]      src2_spec,
    input  logic [XLEN-1:0] src1_data,
    input  logic [XLEN-1:0] src2_data,
    input  logic [VLW-1:0]  vl,
    output logic            out_valid,
    output logic [XLEN-1:0] out_data
);
    elem_kind_t      kind;
    alu_op_e         op_e;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] res_b8;
    logic [XLEN-1:0] res_b16;
    logic [XLEN-1:0] res_sel;
    emit_state_e     state_q;
    emit_state_e     state_d;
    logic [XLEN-1:0] data_q;

    assign op_e = alu_op_e'(op);

    simd_spec_decode i_dec (
        .spec (dst_spec),
        .kind (kind)
    );

    // specifier 0 is the hardwired-zero register
    assign opnd_a = (src1_spec == 5'd0) ? '0 : src1_data;
    assign opnd_b = (src2_spec == 5'd0) ? '0 : src2_data;

    simd_lane_array #(.XLEN(XLEN), .EW(8), .MVL(MVL), .VLW(VLW)) i_arr8 (
        .op          (op_e),
        .is_unsigned (kind.is_unsigned),
        .vl          (vl),
        .a           (opnd_a),
        .b           (opnd_b),
        .r           (res_b8)
    );

    simd_lane_array #(.XLEN(XLEN), .EW(16), .MVL(MVL), .VLW(VLW)) i_arr16 (
        .op          (op_e),
        .is_unsigned (kind.is_unsigned),
        .vl          (vl),
        .a           (opnd_a),
        .b           (opnd_b),
        .r           (res_b16)
    );

    assign res_sel = kind.wide ? res_b16 : res_b8;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;   // accept
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;   // drain (else stream)
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (in_valid) data_q <= res_sel;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_data  = data_q;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_zero_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src1_spec == 5'd0 && src2_spec == 5'd0 && op == 2'd3
         && 32'(vl) >= MVL) |=> (out_data == '1));

    for (genvar i = 0; i < MVL; i++) begin : g_chk
        p_tail8_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !dst_spec[4] && 32'(vl) <= i) |=> (out_data[i*8 +: 8] == 8'd0));
        p_tail16_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && dst_spec[4] && 32'(vl) <= i) |=> (out_data[i*16 +: 16] == 16'd0));
    end
endmodule

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
    localparam int XLEN = 32;
    localparam int MVL  = XLEN / 16;
    localparam int VLW  = $clog2(MVL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      op = 2'd0;
    logic [4:0]      dst_spec = 5'd0;
    logic [4:0]      src1_spec = 5'd0;
    logic [4:0]      src2_spec = 5'd0;
    logic [XLEN-1:0] src1_data = '0;
    logic [XLEN-1:0] src2_data = '0;
    logic [VLW-1:0]  vl = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_data;

    int checks = 0;
    int failures = 0;
    logic            exp_valid = 1'b0;
    logic [XLEN-1:0] exp_data = '0;
    string           exp_tag = "R10";

    always #10 clk = ~clk;

    simd_lane_alu #(.XLEN(XLEN)) i_simd_lane_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .dst_spec(dst_spec), .src1_spec(src1_spec), .src2_spec(src2_spec),
        .src1_data(src1_data), .src2_data(src2_data), .vl(vl),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [XLEN-1:0] model(input logic [1:0] o, input logic [4:0] d,
            input logic [4:0] s1, input logic [4:0] s2, input logic [XLEN-1:0] a,
            input logic [XLEN-1:0] b, input int v);
        int ew = d[4] ? 16 : 8;
        longint full = longint'(1) << ew;
        longint mask = full - 1;
        logic [XLEN-1:0] res = '0;
        longint ua = (s1 == 0) ? 0 : longint'(a);
        longint ub = (s2 == 0) ? 0 : longint'(b);
        for (int i = 0; i < XLEN / ew; i++) begin
            longint x = (ua >> (i * ew)) & mask;
            longint y = (ub >> (i * ew)) & mask;
            longint xs = (!d[3] && x >= full / 2) ? x - full : x;
            longint ys = (!d[3] && y >= full / 2) ? y - full : y;
            longint r = 0;
            case (o)
                2'd0: r = (x + y) & mask;
                2'd1: r = (x - y) & mask;
                2'd2: r = (xs < ys) ? mask : 0;
                default: r = (x == y) ? mask : 0;
            endcase
            if (i < MVL && i >= v) r = 0;
            res = res | XLEN'(r << (i * ew));
        end
        return res;
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== exp_valid) begin
            failures++;
            $display("FAIL R10 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
        end
        if (exp_valid) begin
            checks++;
            if (out_data !== exp_data) begin
                failures++;
                $display("FAIL %s out_data actual=%h expected=%h", exp_tag, out_data, exp_data);
            end
        end
    endtask

    task automatic cycle(input logic iv, input logic [1:0] o, input logic [4:0] d,
            input logic [4:0] s1, input logic [4:0] s2, input logic [XLEN-1:0] a,
            input logic [XLEN-1:0] b, input int v, input string tag);
        @(negedge clk);
        check_out();
        in_valid = iv; op = o; dst_spec = d; src1_spec = s1; src2_spec = s2;
        src1_data = a; src2_data = b; vl = VLW'(v);
        exp_valid = iv;
        if (iv) exp_data = model(o, d, s1, s2, a, b, v);
        exp_tag = tag;
    endtask

    task automatic idle();
        cycle(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, '0, '0, 0, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R10 reset state
        if (out_valid !== 1'b0 || out_data !== '0) begin
            failures++;
            $display("FAIL R10 reset actual=%0b/%h expected=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;
        // R3: INT8 signed add, lane wrap without carry into neighbours
        cycle(1, 0, 5'd2, 5'd5, 5'd6, 32'h01FF_80FF, 32'h0101_8001, 2, "R3");
        // R4: INT16 unsigned subtract with per-lane borrow
        cycle(1, 1, 5'd25, 5'd5, 5'd6, 32'h0000_0001, 32'h0001_0002, 2, "R4");
        // R2/R5: same data signed vs unsigned less-than
        cycle(1, 2, 5'd3, 5'd5, 5'd6, 32'h8080_0180, 32'h0101_8001, 2, "R2 R5 signed");
        cycle(1, 2, 5'd11, 5'd5, 5'd6, 32'h8080_0180, 32'h0101_8001, 2, "R2 R5 unsigned");
        cycle(1, 2, 5'd17, 5'd5, 5'd6, 32'h8000_0001, 32'h0001_8000, 2, "R5 int16");
        // R6: equality masks
        cycle(1, 3, 5'd4, 5'd5, 5'd6, 32'h1122_3344, 32'h1122_0044, 2, "R6");
        idle();
        // R1: same operands read as INT8 then INT16
        cycle(1, 0, 5'd2, 5'd5, 5'd6, 32'h00FF_00FF, 32'h0001_0001, 2, "R1 int8");
        cycle(1, 0, 5'd18, 5'd5, 5'd6, 32'h00FF_00FF, 32'h0001_0001, 2, "R1 int16");
        // R7/R8: VL tail zeroing below MVL, lanes beyond MVL still computed
        cycle(1, 0, 5'd2, 5'd5, 5'd6, 32'h1111_1111, 32'h0101_0101, 0, "R7 R8 vl0");
        cycle(1, 0, 5'd2, 5'd5, 5'd6, 32'h1111_1111, 32'h0101_0101, 1, "R7 R8 vl1");
        cycle(1, 3, 5'd20, 5'd5, 5'd6, 32'h0, 32'h0, 1, "R7 int16");
        // R9: source specifier 0 reads zero
        cycle(1, 0, 5'd2, 5'd0, 5'd6, 32'hFFFF_FFFF, 32'h0102_0304, 2, "R9 src1");
        cycle(1, 3, 5'd2, 5'd0, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0, 2, "R9 both");
        idle(); idle();
        for (int k = 0; k < 400; k++) begin
            logic [1:0] ro = 2'($urandom_range(0, 3));
            string t = (ro == 0) ? "R3" : (ro == 1) ? "R4" : (ro == 2) ? "R5" : "R6";
            cycle(1'($urandom_range(0, 3) != 0), ro, 5'($urandom_range(0, 29)),
                  5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                  XLEN'($urandom), XLEN'($urandom), $urandom_range(0, 3), t);
        end
        idle(); idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule